// File: doc/BRIEF.md
# System Control and Debug Register Bank

This block keeps the processor's indexed system state in one place: paging and protection control words, the extended-feature word, eight debug words, a time-stamp counter, code and stack segment attribute words, and eight segment bases, each paired with an effective base. A single write port serves two callers. State save and restore use the raw path, which stores the value exactly as given. Instruction execution uses the architectural path, which also applies the side effects of the write.

On an architectural write the bank can do several things. It can update the long-mode-active bit. It forces the control bits that must always be set and keeps the debug words' read-only fields. It redirects two debug aliases to their targets. It keeps the effective bases consistent with the mode. It also pulses translation-cache flush requests and a strobe that tells the mode decoder to recompute. Reads are combinational and take a single cycle. The time-stamp counter is held as an offset from a free-running cycle counter, so it advances without being written.

Top module: `sysreg_bank`

## Requirements
- R1: Index map: CRn at index n (0 to 15), extended-feature word 16, DRn at 17+n, time-stamp counter 25, code attributes 26, stack attributes 27, bases of ES, CS, SS, DS, FS, GS, TR, IDTR at 28 to 35, and their effective bases at 36 to 43. After a synchronous active-low reset every word reads 0, except DR6, which reads 0xFFFF0FF0, and DR7, which reads 0x400.
- R2: Indices 1, 5 to 7, 9 to 15 and 44 and above are illegal. For such an index `rd_err` is 1 and `rd_data` is 0. A write with `wr_en` to such an index raises `wr_err` in the same cycle, changes no word, and raises no pulse.
- R3: An architectural CR0 write always stores bit 4 as 1. If it flips bit 31 (paging) while bit 8 of the extended-feature word is 1, bit 10 of that word takes the new bit 31 value in the same update.
- R4: The flush pulses are combinational and appear in the cycle the write is presented. A paging flip on CR0, or a CR4 write that flips bit 4, 5 or 7, raises `flush_all`. Any CR3 write raises `flush_ng`. The two pulses are never high together, and `flush_all` wins.
- R5: An architectural write to DR4 acts on DR6, and one to DR5 acts on DR7. The DR4 and DR5 words themselves are unchanged.
- R6: An architectural DR6 write changes only bits 0 to 3, 13, 14 and 15. All other bits keep their value.
- R7: An architectural DR7 write changes only bits 0 to 7, 13 and 16 to 31. `bp_unsup` is 1 whenever any of DR7 bits 0 to 7 is 1.
- R8: An architectural time-stamp write of V makes later reads return V plus the number of clock edges since the write.
- R9: An architectural write to the code attributes that flips bit 0 (long) has one of two effects on the effective bases of ES, CS, SS and DS. A flip to 1 clears them. A flip to 0 reloads each of them from its base.
- R10: An architectural write to the FS, GS, TR or IDTR base also stores the value in the matching effective base. An architectural write to the ES, CS, SS or DS base does the same only when extended-feature bit 10 or code-attribute bit 0 is 0.
- R11: `mode_upd` is 1 in the cycle of every legal architectural write to CR0, the code attributes or the stack attributes, and in no other cycle.
- R12: A raw write stores the value unchanged in the indexed word and does nothing else: no alias, no mask, no forced bit, no base copy and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_arch | input | 1 | 1 = architectural write, 0 = raw write |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write value |
| wr_err | output | 1 | Write targets an illegal index |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read value (counter adjusted for index 25) |
| rd_err | output | 1 | Read index illegal |
| flush_all | output | 1 | Full translation flush request pulse |
| flush_ng | output | 1 | Non-global translation flush request pulse |
| mode_upd | output | 1 | Mode decoder recompute strobe |
| bp_unsup | output | 1 | A breakpoint enable is set in DR7 |

## Verification
A CR0 write that flips paging while long mode is enabled does several things in the same cycle: it updates bit 10 of the extended-feature word, raises the full flush and raises the mode strobe. The bench presents such writes in both directions and samples all three pulses before the edge. It then reads back CR0 and the extended-feature word after the edge. A code-attribute write likewise combines the mode strobe with the rewrite of four effective bases. The bench checks this with different values in the bases, so a clear can be told apart from a reload.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
    localparam int XLEN  = 64;
    localparam int NREG  = 44;
    localparam int IDX_W = 6;

    // Word indices
    localparam int IX_CR0    = 0;
    localparam int IX_CR3    = 3;
    localparam int IX_CR4    = 4;
    localparam int IX_EFER   = 16;
    localparam int IX_DR4    = 21;
    localparam int IX_DR5    = 22;
    localparam int IX_DR6    = 23;
    localparam int IX_DR7    = 24;
    localparam int IX_TSC    = 25;
    localparam int IX_CSATTR = 26;
    localparam int IX_SSATTR = 27;
    localparam int IX_BASE0  = 28;
    localparam int IX_EFF0   = 36;
    localparam int NSEG      = 8;
    localparam int NSEG_LEG  = 4;   // first four segments gated in 64-bit mode

    // Bit positions
    localparam int B_ET  = 4;
    localparam int B_PG  = 31;
    localparam int B_LME = 8;
    localparam int B_LMA = 10;
    localparam int B_CSL = 0;

    localparam logic [XLEN-1:0] CR4_PGMASK = XLEN'(64'h0000_00B0);
    localparam logic [XLEN-1:0] DR6_WMASK  = XLEN'(64'h0000_E00F);
    localparam logic [XLEN-1:0] DR7_WMASK  = XLEN'(64'hFFFF_20FF);
    localparam logic [XLEN-1:0] DR6_RST    = XLEN'(64'hFFFF_0FF0);
    localparam logic [XLEN-1:0] DR7_RST    = XLEN'(64'h0000_0400);
endpackage

// File: rtl/sysreg_idx_check.sv
// Classifies an index as legal or illegal.
// Assumes the index map of sysreg_pkg: holes among the control words and
// anything at or above NREG are illegal.
module sysreg_idx_check #(
    parameter int IDX_W = sysreg_pkg::IDX_W,
    parameter int NREG  = sysreg_pkg::NREG
) (
    input  logic [IDX_W-1:0] idx,
    output logic             legal
);
    int k;
    // Purpose: decode index holes and out-of-range values.
    always_comb begin
        k = int'(idx);
        legal = (k < NREG) && (k != 1) && !(k >= 5 && k <= 7) && !(k >= 9 && k <= 15);
    end
endmodule

// File: rtl/sysreg_cycle_ctr.sv
// Free-running cycle counter that serves as the time base of the stamp counter.
// Assumes wrap-around at 2**W is acceptable.
module sysreg_cycle_ctr #(
    parameter int W = sysreg_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cyc
);
    // Purpose: count every clock edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end
endmodule

// File: rtl/sysreg_side.sv
// Computes the next value of every word and the pulses for one write.
// Assumes at most one write per cycle and a legal-index flag from the caller.
module sysreg_side
    import sysreg_pkg::*;
#(
    parameter int XLEN  = sysreg_pkg::XLEN,
    parameter int NREG  = sysreg_pkg::NREG,
    parameter int IDX_W = sysreg_pkg::IDX_W
) (
    input  logic             wr_en,
    input  logic             wr_arch,
    input  logic             wr_legal,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  cyc,
    input  logic [XLEN-1:0]  cur [NREG],
    output logic [NREG-1:0]  we,
    output logic [XLEN-1:0]  nv [NREG],
    output logic             flush_all,
    output logic             flush_ng,
    output logic             mode_upd
);
    int              k;
    int              seg;
    logic            pg_flip;
    logic            l_flip;
    logic            mode64;
    logic            ng_req;
    logic [XLEN-1:0] cr0_nx;
    logic [XLEN-1:0] efer_nx;

    // Purpose: apply raw or architectural write rules to form next state.
    always_comb begin
        we        = '0;
        for (int i = 0; i < NREG; i++) nv[i] = cur[i];
        flush_all = 1'b0;
        ng_req    = 1'b0;
        mode_upd  = 1'b0;
        k         = int'(wr_idx);
        seg       = 0;
        pg_flip   = cur[IX_CR0][B_PG] ^ wr_data[B_PG];
        l_flip    = cur[IX_CSATTR][B_CSL] ^ wr_data[B_CSL];
        mode64    = cur[IX_EFER][B_LMA] & cur[IX_CSATTR][B_CSL];
        cr0_nx    = wr_data;
        cr0_nx[B_ET] = 1'b1;
        efer_nx   = cur[IX_EFER];
        efer_nx[B_LMA] = wr_data[B_PG];
        if (wr_en && wr_legal) begin
            if (!wr_arch) begin
                we[k] = 1'b1;
                nv[k] = wr_data;
            end else begin
                case (k)
                    IX_CR0: begin
                        if (pg_flip && cur[IX_EFER][B_LME]) begin
                            we[IX_EFER] = 1'b1;
                            nv[IX_EFER] = efer_nx;
                        end
                        flush_all = pg_flip;
                        mode_upd  = 1'b1;
                        we[k]     = 1'b1;
                        nv[k]     = cr0_nx;
                    end
                    IX_CR3: begin
                        ng_req = 1'b1;
                        we[k]  = 1'b1;
                        nv[k]  = wr_data;
                    end
                    IX_CR4: begin
                        flush_all = |((cur[IX_CR4] ^ wr_data) & CR4_PGMASK);
                        we[k]     = 1'b1;
                        nv[k]     = wr_data;
                    end
                    IX_DR4, IX_DR6: begin
                        we[IX_DR6] = 1'b1;
                        nv[IX_DR6] = (cur[IX_DR6] & ~DR6_WMASK) | (wr_data & DR6_WMASK);
                    end
                    IX_DR5, IX_DR7: begin
                        we[IX_DR7] = 1'b1;
                        nv[IX_DR7] = (cur[IX_DR7] & ~DR7_WMASK) | (wr_data & DR7_WMASK);
                    end
                    IX_TSC: begin
                        we[k] = 1'b1;
                        nv[k] = wr_data - cyc;
                    end
                    IX_CSATTR: begin
                        mode_upd = 1'b1;
                        if (l_flip) begin
                            for (int s = 0; s < NSEG_LEG; s++) begin
                                we[IX_EFF0+s] = 1'b1;
                                nv[IX_EFF0+s] = wr_data[B_CSL] ? '0 : cur[IX_BASE0+s];
                            end
                        end
                        we[k] = 1'b1;
                        nv[k] = wr_data;
                    end
                    IX_SSATTR: begin
                        mode_upd = 1'b1;
                        we[k]    = 1'b1;
                        nv[k]    = wr_data;
                    end
                    default: begin
                        we[k] = 1'b1;
                        nv[k] = wr_data;
                        if (k >= IX_BASE0 && k < IX_BASE0 + NSEG) begin
                            seg = k - IX_BASE0;
                            if (seg >= NSEG_LEG || !mode64) begin
                                we[IX_EFF0+seg] = 1'b1;
                                nv[IX_EFF0+seg] = wr_data;
                            end
                        end
                    end
                endcase
            end
        end
        flush_ng = ng_req & ~flush_all;
    end
endmodule

// File: rtl/sysreg_bank.sv
// Top of the system register bank: storage, read mux and write rules.
// Assumes one write and one read per cycle; reads are combinational.
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int XLEN  = sysreg_pkg::XLEN,
    parameter int NREG  = sysreg_pkg::NREG,
    parameter int IDX_W = sysreg_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_arch,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_err,
    output logic             flush_all,
    output logic             flush_ng,
    output logic             mode_upd,
    output logic             bp_unsup
);
    logic [XLEN-1:0] regs [NREG];
    logic [XLEN-1:0] nv   [NREG];
    logic [NREG-1:0] we;
    logic [XLEN-1:0] cyc;
    logic            wr_legal;
    logic            rd_legal;
    int              rk;

    sysreg_idx_check #(.IDX_W(IDX_W), .NREG(NREG)) wchk_i (.idx(wr_idx), .legal(wr_legal));
    sysreg_idx_check #(.IDX_W(IDX_W), .NREG(NREG)) rchk_i (.idx(rd_idx), .legal(rd_legal));

    sysreg_cycle_ctr #(.W(XLEN)) ctr_i (.clk(clk), .rst_n(rst_n), .cyc(cyc));

    sysreg_side #(.XLEN(XLEN), .NREG(NREG), .IDX_W(IDX_W)) side_i (
        .wr_en(wr_en), .wr_arch(wr_arch), .wr_legal(wr_legal), .wr_idx(wr_idx),
        .wr_data(wr_data), .cyc(cyc), .cur(regs), .we(we), .nv(nv),
        .flush_all(flush_all), .flush_ng(flush_ng), .mode_upd(mode_upd)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_word
        localparam logic [XLEN-1:0] RV = (g == IX_DR6) ? DR6_RST :
                                         (g == IX_DR7) ? DR7_RST : '0;
        // Purpose: hold one word, loading its reset value or next value.
        always_ff @(posedge clk) begin
            if (!rst_n)     regs[g] <= RV;
            else if (we[g]) regs[g] <= nv[g];
        end
    end

    // Purpose: select the read word and add the cycle base for the counter.
    always_comb begin
        rk      = rd_legal ? int'(rd_idx) : 0;
        rd_data = '0;
        if (rd_legal) rd_data = (rk == IX_TSC) ? regs[rk] + cyc : regs[rk];
    end

    assign rd_err   = ~rd_legal;
    assign wr_err   = wr_en & ~wr_legal;
    assign bp_unsup = |regs[IX_DR7][7:0];
endmodule

// File: rtl/sysreg_bank_chk.sv
// Temporal checks for sysreg_bank, attached by bind.
module sysreg_bank_chk #(
    parameter int IDX_W = sysreg_pkg::IDX_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_arch,
    input logic             wr_err,
    input logic [IDX_W-1:0] wr_idx,
    input logic             wr_pg,
    input logic             flush_all,
    input logic             flush_ng,
    input logic             mode_upd,
    input logic             cr0_pg,
    input logic             cr0_et,
    input logic             efer_lme,
    input logic             efer_lma,
    input logic             dr7_b10
);
    logic cr0_arch;
    assign cr0_arch = wr_en && wr_arch && !wr_err && (wr_idx == IDX_W'(0));

    p_et_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_arch |=> cr0_et);

    p_lma_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_arch && efer_lme && (cr0_pg != wr_pg)) |=> (efer_lma == $past(wr_pg)));

    p_flush_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_all, flush_ng}));

    p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_err) |-> !(flush_all || flush_ng || mode_upd));

    p_strobe_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_upd |-> (wr_en && wr_arch && !wr_err));

    p_raw_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_arch) |-> !(flush_all || flush_ng || mode_upd));

    p_dr7_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_arch && (wr_idx == IDX_W'(24))) |=> (dr7_b10 == $past(dr7_b10)));
endmodule

bind sysreg_bank sysreg_bank_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arch(wr_arch), .wr_err(wr_err),
    .wr_idx(wr_idx), .wr_pg(wr_data[31]), .flush_all(flush_all), .flush_ng(flush_ng),
    .mode_upd(mode_upd), .cr0_pg(regs[0][31]), .cr0_et(regs[0][4]),
    .efer_lme(regs[16][8]), .efer_lma(regs[16][10]), .dr7_b10(regs[24][10])
);

// File: tb/sysreg_bank_tb_top.sv
`timescale 1ns/1ps
module sysreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_arch = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [5:0]  rd_idx = '0;
    logic        wr_err, rd_err, flush_all, flush_ng, mode_upd, bp_unsup;
    logic [63:0] rd_data;
    int checks = 0;
    int errors = 0;
    logic s_fa, s_fng, s_mu, s_err;

    always #4 clk = ~clk;

    sysreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arch(wr_arch), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(wr_err), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_err(rd_err), .flush_all(flush_all), .flush_ng(flush_ng),
        .mode_upd(mode_upd), .bp_unsup(bp_unsup)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic arch, input int idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_arch = arch; wr_idx = idx[5:0]; wr_data = d;
        #2;
        s_fa = flush_all; s_fng = flush_ng; s_mu = mode_upd; s_err = wr_err;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] v);
        rd_idx = idx[5:0];
        #1 v = rd_data;
    endtask

    task automatic rchk(input string tag, input int idx, input logic [63:0] exp);
        logic [63:0] v;
        rd(idx, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        rchk("R1 CR0 reset", 0, 64'h0);
        rchk("R1 EFER reset", 16, 64'h0);
        rchk("R1 DR6 reset", 23, 64'hFFFF_0FF0);
        rchk("R1 DR7 reset", 24, 64'h400);
        rchk("R1 eff ES reset", 36, 64'h0);
        chk("R1 flags idle", {flush_all, flush_ng, mode_upd, bp_unsup, wr_err}, 64'h0);
    endtask

    task automatic t_illegal;
        logic [63:0] v;
        rd(1, v);  chk("R2 rd CR1 err", rd_err, 1); chk("R2 rd CR1 data", v, 0);
        rd(6, v);  chk("R2 rd CR6 err", rd_err, 1);
        rd(15, v); chk("R2 rd CR15 err", rd_err, 1);
        rd(50, v); chk("R2 rd idx50 err", rd_err, 1);
        rd(8, v);  chk("R2 rd CR8 legal", rd_err, 0);
        wr(1'b1, 1, 64'hFF);
        chk("R2 wr CR1 err", s_err, 1);
        chk("R2 wr CR1 no pulse", {s_fa, s_fng, s_mu}, 0);
        rchk("R2 CR1 unchanged", 1, 0);
        rchk("R2 CR0 untouched", 0, 0);
        wr(1'b0, 7, 64'h55);
        chk("R2 raw wr CR7 err", s_err, 1);
        wr(1'b1, 8, 64'h5);
        chk("R2 wr CR8 no err", s_err, 0);
        rchk("R2 CR8 stored", 8, 64'h5);
    endtask

    task automatic t_cr0;
        wr(1'b0, 16, 64'h100);
        chk("R12 raw EFER quiet", {s_fa, s_fng, s_mu}, 0);
        wr(1'b1, 0, 64'h8000_0001);
        chk("R4 PG on flush_all", s_fa, 1);
        chk("R4 PG on no ng", s_fng, 0);
        chk("R11 CR0 strobe", s_mu, 1);
        rchk("R3 CR0 ET forced", 0, 64'h8000_0011);
        rchk("R3 LMA set", 16, 64'h500);
        wr(1'b1, 0, 64'h1);
        chk("R4 PG off flush_all", s_fa, 1);
        rchk("R3 LMA clear", 16, 64'h100);
        rchk("R3 CR0 value", 0, 64'h11);
        wr(1'b1, 0, 64'h3);
        chk("R4 no PG flip no flush", s_fa, 0);
        chk("R11 CR0 strobe again", s_mu, 1);
        rchk("R3 CR0 ET kept", 0, 64'h13);
        wr(1'b0, 16, 64'h0);
        wr(1'b1, 0, 64'h8000_0000);
        chk("R4 flip without LME", s_fa, 1);
        rchk("R3 LMA stays 0 without LME", 16, 64'h0);
        wr(1'b1, 0, 64'h0);
        rchk("R3 CR0 ET after clear", 0, 64'h10);
    endtask

    task automatic t_flush;
        wr(1'b1, 3, 64'h1000);
        chk("R4 CR3 ng", s_fng, 1);
        chk("R4 CR3 no full", s_fa, 0);
        chk("R11 CR3 no strobe", s_mu, 0);
        wr(1'b1, 4, 64'h20);
        chk("R4 CR4 PAE flush", s_fa, 1);
        wr(1'b1, 4, 64'h21);
        chk("R4 CR4 other bit no flush", {s_fa, s_fng}, 0);
        wr(1'b1, 4, 64'h01);
        chk("R4 CR4 PAE off flush", s_fa, 1);
        wr(1'b1, 4, 64'h81);
        chk("R4 CR4 PGE flush", s_fa, 1);
        wr(1'b1, 4, 64'h91);
        chk("R4 CR4 PSE flush", s_fa, 1);
        wr(1'b0, 4, 64'h0);
        chk("R12 raw CR4 no flush", s_fa, 0);
    endtask

    task automatic t_dbg;
        wr(1'b1, 21, 64'hFFFF_FFFF_FFFF_FFFF);
        rchk("R6 DR4 alias mask", 23, 64'hFFFF_EFFF);
        rchk("R5 DR4 word untouched", 21, 64'h0);
        wr(1'b1, 23, 64'h0);
        rchk("R6 DR6 clear writable", 23, 64'hFFFF_0FF0);
        wr(1'b1, 22, 64'hFFFF_FFFF_FFFF_FFFF);
        rchk("R7 DR5 alias mask", 24, 64'hFFFF_24FF);
        rchk("R5 DR5 word untouched", 22, 64'h0);
        chk("R7 unsup raised", bp_unsup, 1);
        wr(1'b1, 24, 64'h0);
        rchk("R7 DR7 cleared", 24, 64'h400);
        chk("R7 unsup dropped", bp_unsup, 0);
        wr(1'b1, 24, 64'hFFFF_2000);
        rchk("R7 DR7 fields", 24, 64'hFFFF_2400);
        chk("R7 no enable no unsup", bp_unsup, 0);
        wr(1'b1, 24, 64'h4);
        chk("R7 L1 unsup", bp_unsup, 1);
        wr(1'b1, 24, 64'h0);
        wr(1'b1, 17, 64'h1234);
        rchk("R1 DR0 plain", 17, 64'h1234);
    endtask

    task automatic t_tsc;
        logic [63:0] v;
        wr(1'b1, 25, 64'd1000);
        rd(25, v);
        chk("R8 stamp after write", v, 64'd1001);
        repeat (5) @(posedge clk);
        #1 rd(25, v);
        chk("R8 stamp advances", v, 64'd1006);
    endtask

    task automatic t_seg;
        wr(1'b0, 16, 64'h500);
        wr(1'b1, 28, 64'h1000);
        rchk("R10 ES eff copy legacy", 36, 64'h1000);
        wr(1'b1, 26, 64'h1);
        chk("R11 CS attr strobe", s_mu, 1);
        rchk("R9 ES eff cleared", 36, 64'h0);
        wr(1'b1, 31, 64'h2000);
        rchk("R10 DS eff gated in 64-bit", 39, 64'h0);
        wr(1'b1, 32, 64'h3000);
        rchk("R10 FS eff always", 40, 64'h3000);
        wr(1'b1, 26, 64'h0);
        rchk("R9 ES eff reloaded", 36, 64'h1000);
        rchk("R9 DS eff reloaded", 39, 64'h2000);
        wr(1'b1, 34, 64'h4000);
        rchk("R10 TR eff always", 42, 64'h4000);
        wr(1'b1, 27, 64'h1);
        chk("R11 SS attr strobe", s_mu, 1);
        chk("R4 SS attr no flush", s_fa, 0);
        wr(1'b0, 16, 64'h0);
        wr(1'b0, 26, 64'h1);
        chk("R12 raw CS attr no strobe", s_mu, 0);
        rchk("R12 raw CS attr no eff clear", 36, 64'h1000);
        wr(1'b1, 29, 64'h6000);
        rchk("R10 CS eff copy when LMA clear", 37, 64'h6000);
    endtask

    task automatic t_raw;
        wr(1'b0, 16, 64'h100);
        wr(1'b0, 0, 64'h8000_0000);
        chk("R12 raw CR0 quiet", {s_fa, s_fng, s_mu}, 0);
        rchk("R12 raw CR0 exact", 0, 64'h8000_0000);
        rchk("R12 raw CR0 no LMA", 16, 64'h100);
        wr(1'b0, 21, 64'h77);
        rchk("R12 raw DR4 own word", 21, 64'h77);
        rchk("R12 raw DR4 no alias", 23, 64'hFFFF_0FF0);
        wr(1'b0, 28, 64'h9999);
        rchk("R12 raw base no copy", 36, 64'h1000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_illegal;
        t_cr0;
        t_flush;
        t_dbg;
        t_tsc;
        t_seg;
        t_raw;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule